// File: doc/BRIEF.md
# Thread-Busy Backpressure Generator

This block produces a single busy flag that imitates a component whose internal queues have filled. It keeps an 8-bit estimate of its own occupancy. The busy flag is raised when that estimate passes a programmed upper level. A test environment places it beside a request/response port. The port then stalls the way a real slave or master with limited buffering would.

A two-bit mode input selects the occupancy estimate:

- **Leaky modes.** A counter gains a programmed weight on each qualifying event and loses one on every clock.
  - In the slave flavour the qualifying event is an accepted request.
  - In the master flavour the qualifying event is a received response, and the flag uses hysteresis with separate upper and lower levels.
- **Difference modes.** The count is accepted requests minus completed data handshakes, or accepted requests minus completed responses.

In every slave mode, a request strobe that arrives while the flag is high is not accepted and is not counted.

Top module: `thread_busy_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both occupancy counters are cleared and `busy_o` is 0 after that edge.
- R2: In mode 0 (leaky, slave), each accepted request adds `inc_i` and every clock subtracts one, applied together as one net update. The busy decision is strictly count > `hi_thr_i`.
- R3: `busy_o` is registered: it reflects the occupancy count held during the previous cycle, so it changes one clock after the count crosses a level.
- R4: No occupancy count goes below zero: idle clocks in a leaky mode, and completions in a difference mode, leave a zero count at zero.
- R5: No occupancy count wraps past 255. An update that would exceed 255 leaves the count at 255.
- R6: In mode 3 (leaky, master), each `resp_i` strobe adds `inc_i` and every clock subtracts one. Busy is set when count > `hi_thr_i` and cleared only when count < `lo_thr_i`; between the two levels it holds.
- R7: In mode 1, occupancy is accepted requests minus `data_i` strobes, and `resp_i` has no effect.
- R8: In mode 2, occupancy is accepted requests minus `resp_i` strobes, and `data_i` has no effect.
- R9: In modes 0, 1 and 2, a `req_i` strobe sampled while `busy_o` is 1 is not accepted and changes no count.
- R10: In a difference mode, an accepted request and a completion in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Occupancy estimate: 0 leaky slave, 1 req minus data, 2 req minus resp, 3 leaky master |
| req_i | input | 1 | Request strobe, one per cycle |
| data_i | input | 1 | Data-handshake completion strobe |
| resp_i | input | 1 | Response strobe |
| inc_i | input | 4 | Weight added per qualifying event in leaky modes (1 to 15) |
| hi_thr_i | input | 8 | Upper level |
| lo_thr_i | input | 8 | Lower level, used by the master hysteresis only |
| busy_o | output | 1 | Registered busy flag |

## Verification
The bench aims at the edges of the count and of the comparison.

- **Floor and saturation.** A count that wraps below zero would show as immediate busy after idle cycles or stray completions. A count that wraps above 255 would drop busy in the middle of a saturated burst.
- **Comparison and lag.** A count equal to the upper level must not be busy, which catches an inclusive comparison. A flag that follows the count in the same cycle would show its change one cycle early.
- **Hysteresis.** A master flag without hysteresis would fall between the two levels.
- **Gating and strobe routing.** Requests sent during busy would delay the release if they were counted. A strobe routed to the wrong mode would move the release point.
- **Simultaneous events.** A request and a completion in the same cycle must cancel; a priority scheme instead of cancellation would miss the later busy.

// File: rtl/tbusy_pkg.sv
package tbusy_pkg;

    localparam int OCC_W = 8;
    localparam int WGT_W = 4;

    typedef enum logic [1:0] {
        OCC_LEAKY_SLV = 2'd0,
        OCC_REQ_DATA  = 2'd1,
        OCC_REQ_RESP  = 2'd2,
        OCC_LEAKY_MST = 2'd3
    } occ_mode_e;

    typedef struct packed {
        logic req_acc;
        logic data_done;
        logic resp_done;
    } evt_t;

    function automatic logic is_slave_mode(occ_mode_e m);
        return m != OCC_LEAKY_MST;
    endfunction

endpackage

// File: rtl/tbg_leak_ctr.sv
module tbg_leak_ctr #(
    parameter int CNT_W = 8,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [CNT_W-1:0] MAX_C = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] add;
    logic             neg, ovf;

    always_comb begin
        add = ev_i ? {{(SUM_W-INC_W){1'b0}}, inc_i} : '0;
        sum = {2'b00, cnt_q} + add - SUM_W'(1);
        neg = sum[SUM_W-1];
        ovf = !neg && sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (neg) cnt_q <= '0;
        else if (ovf) cnt_q <= MAX_C;
        else          cnt_q <= sum[CNT_W-1:0];
    end

    assign cnt_o = cnt_q;

    p_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !ev_i) |=> (cnt_q == '0));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAX_C && ev_i && inc_i != '0) |=> (cnt_q == MAX_C));
    p_leak_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!ev_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tbg_diff_ctr.sv
module tbg_diff_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [CNT_W-1:0] MAX_C = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic             neg, ovf;

    always_comb begin
        sum = {2'b00, cnt_q} + SUM_W'(acc_i) - SUM_W'(done_i);
        neg = sum[SUM_W-1];
        ovf = !neg && sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (neg) cnt_q <= '0;
        else if (ovf) cnt_q <= MAX_C;
        else          cnt_q <= sum[CNT_W-1:0];
    end

    assign cnt_o = cnt_q;

    p_net_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_i && done_i) |=> $stable(cnt_q));
    p_diff_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !acc_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tbg_busy_dec.sv
module tbg_busy_dec #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic             hyst_i,
    output logic             busy_o
);
    logic busy_q, busy_d;

    always_comb begin
        if (!hyst_i)          busy_d = cnt_i > hi_i;
        else if (cnt_i > hi_i) busy_d = 1'b1;
        else if (cnt_i < lo_i) busy_d = 1'b0;
        else                   busy_d = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy_d;
    end

    assign busy_o = busy_q;

    p_reset_r1: assert property (@(posedge clk) rst |=> !busy_q);
    p_plain_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!hyst_i && cnt_i > hi_i) |=> busy_q);
    p_plain_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (!hyst_i && cnt_i <= hi_i) |=> !busy_q);
    p_hyst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hyst_i && busy_q && cnt_i >= lo_i) |=> busy_q);
endmodule

// File: rtl/thread_busy_gen.sv
module thread_busy_gen
    import tbusy_pkg::*;
#(
    parameter int CNT_W = OCC_W,
    parameter int INC_W = WGT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             req_i,
    input  logic             data_i,
    input  logic             resp_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [CNT_W-1:0] hi_thr_i,
    input  logic [CNT_W-1:0] lo_thr_i,
    output logic             busy_o
);
    occ_mode_e        mode;
    evt_t             evt;
    logic             busy;
    logic             leak_ev, diff_done;
    logic [CNT_W-1:0] leak_cnt, diff_cnt, occ;

    always_comb begin
        mode          = occ_mode_e'(mode_i);
        evt.req_acc   = req_i && !busy && is_slave_mode(mode);
        evt.data_done = data_i;
        evt.resp_done = resp_i;
        leak_ev       = (mode == OCC_LEAKY_MST) ? evt.resp_done : evt.req_acc;
        diff_done     = (mode == OCC_REQ_DATA) ? evt.data_done : evt.resp_done;
        case (mode)
            OCC_REQ_DATA, OCC_REQ_RESP: occ = diff_cnt;
            default:                    occ = leak_cnt;
        endcase
    end

    tbg_leak_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_leak (
        .clk(clk), .rst(rst), .ev_i(leak_ev), .inc_i(inc_i), .cnt_o(leak_cnt)
    );

    tbg_diff_ctr #(.CNT_W(CNT_W)) u_diff (
        .clk(clk), .rst(rst), .acc_i(evt.req_acc), .done_i(diff_done), .cnt_o(diff_cnt)
    );

    tbg_busy_dec #(.CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst(rst), .cnt_i(occ), .hi_i(hi_thr_i), .lo_i(lo_thr_i),
        .hyst_i(mode == OCC_LEAKY_MST), .busy_o(busy)
    );

    assign busy_o = busy;

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != OCC_LEAKY_MST && busy && req_i) |=> (leak_cnt <= $past(leak_cnt)));
endmodule

// File: tb/thread_busy_gen_test.sv
module thread_busy_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic       req_i = 1'b0, data_i = 1'b0, resp_i = 1'b0;
    logic [3:0] inc_i = 4'd1;
    logic [7:0] hi_thr_i = 8'd0, lo_thr_i = 8'd0;
    logic       busy_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thread_busy_gen uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .req_i(req_i), .data_i(data_i),
        .resp_i(resp_i), .inc_i(inc_i), .hi_thr_i(hi_thr_i), .lo_thr_i(lo_thr_i),
        .busy_o(busy_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (busy_o !== exp) begin
            errors++;
            $display("FAIL %s: busy_o got %0b expected %0b", tag, busy_o, exp);
        end
    endtask

    task automatic start(input logic [1:0] m, input logic [3:0] inc,
                         input logic [7:0] hi, input logic [7:0] lo);
        rst = 1'b1; req_i = 0; data_i = 0; resp_i = 0;
        mode_i = m; inc_i = inc; hi_thr_i = hi; lo_thr_i = lo;
        tick(2);
        rst = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset;
        start(2'd0, 4'd1, 8'd0, 8'd0);
        check(1'b0, "R1 reset");
    endtask

    // R2/R3: leaky slave, weight 5, level 10
    task automatic t_leaky_slave;
        start(2'd0, 4'd5, 8'd10, 8'd0);
        req_i = 1; tick(3); req_i = 0;     // count 4, 8, 12
        check(1'b0, "R3 lag: busy still low with count 12");
        tick(1); check(1'b1, "R2 count 12 > 10");
        tick(1); check(1'b1, "R2 count 11 > 10");
        tick(1); check(1'b0, "R2 count 10 not > 10");
    endtask

    // R4: floor in leaky mode
    task automatic t_leaky_floor;
        start(2'd0, 4'd3, 8'd1, 8'd0);
        tick(5); check(1'b0, "R4 idle count stays zero");
        req_i = 1; tick(1); req_i = 0;     // count 2
        tick(1); check(1'b1, "R4 count 2 > 1");
        tick(1); check(1'b0, "R4 count 1 not > 1");
    endtask

    // R9: requests during busy ignored (leaky slave)
    task automatic t_gate;
        start(2'd0, 4'd8, 8'd10, 8'd0);
        req_i = 1; tick(5); req_i = 0;     // count 7,14,21 then 20,19
        tick(9);  check(1'b1, "R9 count 11 still busy");
        tick(1);  check(1'b0, "R9 release when gated requests not counted");
    endtask

    // R5/R6: master leaky with saturation and hysteresis
    task automatic t_master;
        start(2'd3, 4'd15, 8'd250, 8'd240);
        req_i = 1;                          // no effect in master mode
        resp_i = 1; tick(20); resp_i = 0; req_i = 0;
        check(1'b1, "R6 set above upper level");
        tick(10); check(1'b1, "R6 hold between levels (count 245)");
        tick(6);  check(1'b1, "R5 saturated count releases on schedule (240 holds)");
        tick(1);  check(1'b0, "R6 clear below lower level");
    endtask

    // R7/R9/R10: requests minus data, level 2
    task automatic t_req_data;
        start(2'd1, 4'd1, 8'd2, 8'd0);
        req_i = 1; tick(3); req_i = 0;      // count 3
        resp_i = 1; tick(1); resp_i = 0;    // ignored in mode 1
        req_i = 1; tick(1); req_i = 0;      // busy: not accepted
        check(1'b1, "R7 response ignored, count 3 > 2");
        data_i = 1; tick(1); data_i = 0;    // count 2
        tick(1); check(1'b0, "R9 request during busy not counted");
        req_i = 1; data_i = 1; tick(1); data_i = 0; // net zero, count 2
        tick(1); req_i = 0;                 // count 3
        check(1'b0, "R10 count 2 after simultaneous events");
        tick(1); check(1'b1, "R10 count 3 after further request");
    endtask

    // R8/R4: requests minus responses, level 1
    task automatic t_req_resp;
        start(2'd2, 4'd1, 8'd1, 8'd0);
        resp_i = 1; tick(2); resp_i = 0;
        tick(1); check(1'b0, "R4 completions at zero do not underflow");
        req_i = 1; tick(2); req_i = 0;      // count 2
        data_i = 1; tick(1); data_i = 0;    // ignored in mode 2
        tick(1); check(1'b1, "R8 data ignored, count 2 > 1");
        resp_i = 1; tick(1); resp_i = 0;    // count 1
        tick(1); check(1'b0, "R8 response lowers count to 1");
    endtask

    initial begin
        t_reset();
        t_leaky_slave();
        t_leaky_floor();
        t_gate();
        t_master();
        t_req_data();
        t_req_resp();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule